// File: doc/BRIEF.md
# Processing-State Controller for a Small Signal-Processor Core

This block decides which of six operating modes a small signal-processor core is in at every cycle, and it drives the clock enables that follow from that mode. The modes are reset, run, interrupt entry, idle (wait), deep sleep (stop) and halted-for-debug. A core, an interrupt unit and the peripheral set sit around it. Each one takes its clock enable from this block. The core also takes a start-fetch pulse and a vector-table address from it.

Reset has two sources. One is an external pin, which is brought into the clock domain through a two-flop synchroniser. The other is a one-cycle expiry strobe from a watchdog. While the block is in reset it holds the peripherals in reset and raises a load strobe. Alongside that strobe it presents power-on values for three configuration registers. The first is an all-ones address modifier. The second is a cleared interrupt-priority word. The third is a bus-control word in which every wait-state field is at its maximum.

Idle and deep sleep gate different sets of logic. In idle only the core is stopped, so an interrupt can still wake it. In deep sleep the interrupt logic is also off, so only the wake input or a reset can bring the core back.

Top module: `pstate_ctrl`

## Requirements
- R1: The state output is always one of six codes: 0 reset, 1 run, 2 interrupt entry, 3 idle, 4 deep sleep, 5 debug halt. The block reset `rst` puts the state at 0, and clearing `rst` alone does not leave code 0 until the synchroniser has drained.
- R2: If `reset_pin` is high at three consecutive rising edges, the state is 0 after the third of them. After the pin falls, the state stays 0 for exactly two more edges and moves to run on the third.
- R3: A high `wdog_zero` at a rising edge gives state 0 after that edge. This holds in every state and over every other input.
- R4: While the state is 0, `periph_rst` and `cfg_load` are high, `mod_init` is all ones, `ipr_init` is zero and every WS_W-bit field of `bcr_init` is all ones.
- R5: Reset always exits to run. `fetch_start` is high for exactly one cycle, the first cycle in run after reset, and at no other time.
- R6: The clock enables per state are as follows. Run and interrupt entry: core, interrupt and peripheral enables all high. Reset and debug halt: core low, the other two high. Idle: core low, interrupt and peripheral high. Deep sleep: all three low.
- R7: From run, `wait_strobe` leads to idle. In idle, `irq_req` leads to interrupt entry. Stop and wake strobes have no effect in idle.
- R8: From run, `stop_strobe` leads to deep sleep. Interrupt and debug requests there have no effect. Only `wake_req` (to run) or a reset leaves it.
- R9: In interrupt entry, `vec_valid` is high for one cycle and `vec_addr` equals VEC_BASE plus the accepted `irq_vec` shifted left by VEC_SHIFT. The next state is run.
- R10: In run, simultaneous requests are ranked debug, then interrupt, then stop, then wait.
- R11: Debug halt is entered from run or idle on `dbg_req`. It is left only by `dbg_release`, which returns to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| reset_pin | input | 1 | External reset request, asynchronous, active high |
| wdog_zero | input | 1 | Watchdog expiry strobe |
| irq_req | input | 1 | Pending enabled interrupt |
| irq_vec | input | VEC_W | Vector number of the pending interrupt |
| wait_strobe | input | 1 | Wait instruction executed |
| stop_strobe | input | 1 | Stop instruction executed |
| wake_req | input | 1 | Wake-up from deep sleep |
| dbg_req | input | 1 | Debug halt request |
| dbg_release | input | 1 | Debug halt release |
| state_o | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| intc_clk_en | output | 1 | Interrupt logic clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| periph_rst | output | 1 | Reset to the peripherals |
| fetch_start | output | 1 | First-fetch pulse after reset |
| vec_valid | output | 1 | Vector address valid |
| vec_addr | output | ADDR_W | Vector-table entry address |
| cfg_load | output | 1 | Load strobe for the init values |
| mod_init | output | MOD_W | Modifier register reset value |
| ipr_init | output | IPR_W | Interrupt-priority reset value |
| bcr_init | output | BCR_FIELDS*WS_W | Bus-control reset value |

## Verification
The bench fires an interrupt, a debug request and a stop strobe while the block is in deep sleep. A design that left the interrupt logic alive there would wake early instead of holding code 4. It raises every run-state request in the same cycle, and a wrong ranking would land in interrupt entry or idle instead of debug halt. It counts the edges of the pin-reset path in both directions, so a missing or extra synchroniser stage shows up as a one-cycle shift. It also checks the start-fetch pulse after both a pin reset and a watchdog reset. A design that pulsed it on other run entries, or let it last two cycles, would fail there. The largest vector number is used to catch a truncated address.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

    typedef enum logic [2:0] {
        PS_RESET  = 3'd0,
        PS_RUN    = 3'd1,
        PS_EXCEPT = 3'd2,
        PS_IDLE   = 3'd3,
        PS_SLEEP  = 3'd4,
        PS_DEBUG  = 3'd5
    } pstate_e;

    typedef struct packed {
        logic core;
        logic intc;
        logic periph;
    } clk_en_t;

    typedef struct packed {
        logic dbg;
        logic irq;
        logic stop;
        logic wait_i;
        logic wake;
        logic release_i;
    } ps_req_t;

    function automatic clk_en_t enables_for(pstate_e s);
        clk_en_t e;
        case (s)
            PS_RUN, PS_EXCEPT:           e = '{core: 1'b1, intc: 1'b1, periph: 1'b1};
            PS_IDLE, PS_RESET, PS_DEBUG: e = '{core: 1'b0, intc: 1'b1, periph: 1'b1};
            default:                     e = '{core: 1'b0, intc: 1'b0, periph: 1'b0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pstate_rst_sync.sv
module pstate_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic pin_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_in};
    end

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/pstate_fsm.sv
module pstate_fsm
    import pstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    reset_src,
    input  ps_req_t req,
    output pstate_e state,
    output logic    fetch_start,
    output logic    irq_take
);
    pstate_e nxt;

    always_comb begin
        nxt      = state;
        irq_take = 1'b0;
        if (reset_src) begin
            nxt = PS_RESET;
        end else begin
            case (state)
                PS_RESET:  nxt = PS_RUN;
                PS_RUN: begin
                    if (req.dbg)              nxt = PS_DEBUG;
                    else if (req.irq) begin
                        nxt      = PS_EXCEPT;
                        irq_take = 1'b1;
                    end
                    else if (req.stop)        nxt = PS_SLEEP;
                    else if (req.wait_i)      nxt = PS_IDLE;
                end
                PS_EXCEPT: nxt = PS_RUN;
                PS_IDLE: begin
                    if (req.dbg)              nxt = PS_DEBUG;
                    else if (req.irq) begin
                        nxt      = PS_EXCEPT;
                        irq_take = 1'b1;
                    end
                end
                PS_SLEEP:  if (req.wake)      nxt = PS_RUN;
                PS_DEBUG:  if (req.release_i) nxt = PS_RUN;
                default:   nxt = PS_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PS_RESET;
            fetch_start <= 1'b0;
        end else begin
            state       <= nxt;
            fetch_start <= (state == PS_RESET) && (nxt == PS_RUN);
        end
    end
endmodule

// File: rtl/pstate_vec_gen.sv
module pstate_vec_gen #(
    parameter int              VEC_W     = 6,
    parameter int              ADDR_W    = 16,
    parameter int              VEC_SHIFT = 1,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_take,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              in_except,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr
);
    logic [VEC_W-1:0]  held_vec;
    logic [ADDR_W-1:0] wide_vec;

    always_ff @(posedge clk) begin
        if (rst)           held_vec <= '0;
        else if (irq_take) held_vec <= irq_vec;
    end

    assign wide_vec  = ADDR_W'(held_vec);
    assign vec_valid = in_except;
    assign vec_addr  = in_except ? (VEC_BASE + (wide_vec << VEC_SHIFT)) : '0;
endmodule

// File: rtl/pstate_cfg_init.sv
module pstate_cfg_init #(
    parameter int MOD_W      = 16,
    parameter int IPR_W      = 16,
    parameter int BCR_FIELDS = 4,
    parameter int WS_W       = 3
) (
    input  logic                       in_reset,
    output logic                       cfg_load,
    output logic [MOD_W-1:0]           mod_init,
    output logic [IPR_W-1:0]           ipr_init,
    output logic [BCR_FIELDS*WS_W-1:0] bcr_init
);
    localparam logic [WS_W-1:0] WS_MAX = '1;

    assign cfg_load = in_reset;
    assign mod_init = '1;
    assign ipr_init = '0;

    for (genvar f = 0; f < BCR_FIELDS; f++) begin : g_ws
        assign bcr_init[f*WS_W +: WS_W] = WS_MAX;
    end
endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
    import pstate_pkg::*;
#(
    parameter int              VEC_W      = 6,
    parameter int              ADDR_W     = 16,
    parameter int              VEC_SHIFT  = 1,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0,
    parameter int              MOD_W      = 16,
    parameter int              IPR_W      = 16,
    parameter int              BCR_FIELDS = 4,
    parameter int              WS_W       = 3,
    parameter int              SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reset_pin,
    input  logic                       wdog_zero,
    input  logic                       irq_req,
    input  logic [VEC_W-1:0]           irq_vec,
    input  logic                       wait_strobe,
    input  logic                       stop_strobe,
    input  logic                       wake_req,
    input  logic                       dbg_req,
    input  logic                       dbg_release,
    output logic [2:0]                 state_o,
    output logic                       core_clk_en,
    output logic                       intc_clk_en,
    output logic                       periph_clk_en,
    output logic                       periph_rst,
    output logic                       fetch_start,
    output logic                       vec_valid,
    output logic [ADDR_W-1:0]          vec_addr,
    output logic                       cfg_load,
    output logic [MOD_W-1:0]           mod_init,
    output logic [IPR_W-1:0]           ipr_init,
    output logic [BCR_FIELDS*WS_W-1:0] bcr_init
);
    logic    pin_sync;
    logic    reset_src;
    logic    irq_take;
    pstate_e state;
    ps_req_t req;
    clk_en_t en;

    pstate_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_in(reset_pin), .pin_sync(pin_sync)
    );

    assign reset_src = pin_sync | wdog_zero;
    assign req = '{dbg: dbg_req, irq: irq_req, stop: stop_strobe,
                   wait_i: wait_strobe, wake: wake_req, release_i: dbg_release};

    pstate_fsm u_fsm (
        .clk(clk), .rst(rst), .reset_src(reset_src), .req(req),
        .state(state), .fetch_start(fetch_start), .irq_take(irq_take)
    );

    pstate_vec_gen #(
        .VEC_W(VEC_W), .ADDR_W(ADDR_W), .VEC_SHIFT(VEC_SHIFT), .VEC_BASE(VEC_BASE)
    ) u_vec (
        .clk(clk), .rst(rst), .irq_take(irq_take), .irq_vec(irq_vec),
        .in_except(state == PS_EXCEPT), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    pstate_cfg_init #(
        .MOD_W(MOD_W), .IPR_W(IPR_W), .BCR_FIELDS(BCR_FIELDS), .WS_W(WS_W)
    ) u_cfg (
        .in_reset(state == PS_RESET), .cfg_load(cfg_load),
        .mod_init(mod_init), .ipr_init(ipr_init), .bcr_init(bcr_init)
    );

    assign en            = enables_for(state);
    assign state_o       = state;
    assign core_clk_en   = en.core;
    assign intc_clk_en   = en.intc;
    assign periph_clk_en = en.periph;
    assign periph_rst    = (state == PS_RESET);
endmodule

// File: rtl/pstate_ctrl_chk.sv
module pstate_ctrl_chk #(
    parameter int MOD_W      = 16,
    parameter int IPR_W      = 16,
    parameter int BCR_FIELDS = 4,
    parameter int WS_W       = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       reset_pin,
    input logic                       wdog_zero,
    input logic                       irq_req,
    input logic                       wake_req,
    input logic                       dbg_req,
    input logic                       dbg_release,
    input logic [2:0]                 state_o,
    input logic                       core_clk_en,
    input logic                       intc_clk_en,
    input logic                       periph_clk_en,
    input logic                       periph_rst,
    input logic                       fetch_start,
    input logic                       vec_valid,
    input logic                       cfg_load,
    input logic [MOD_W-1:0]           mod_init,
    input logic [IPR_W-1:0]           ipr_init,
    input logic [BCR_FIELDS*WS_W-1:0] bcr_init
);
    assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
        state_o <= 3'd5);

    assert_pin_reset_R2: assert property (@(posedge clk) disable iff (rst)
        reset_pin && $past(reset_pin) && $past(reset_pin, 2) |=> state_o == 3'd0);

    assert_wdog_reset_R3: assert property (@(posedge clk) disable iff (rst)
        wdog_zero |=> state_o == 3'd0);

    assert_init_values_R4: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd0 |-> periph_rst && cfg_load && (&mod_init)
                            && (ipr_init == '0) && (&bcr_init));

    assert_fetch_once_R5: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> state_o == 3'd1 && $past(state_o) == 3'd0);

    assert_idle_gating_R6: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd3 |-> !core_clk_en && intc_clk_en && periph_clk_en);

    assert_sleep_gating_R6: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd4 |-> !core_clk_en && !intc_clk_en && !periph_clk_en);

    assert_idle_irq_R7: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd3 && irq_req && !dbg_req && !wdog_zero && !$past(reset_pin)
        |=> state_o == 3'd2);

    assert_sleep_holds_R8: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd4 && !wake_req && !wdog_zero && !$past(reset_pin)
        |=> state_o == 3'd4);

    assert_except_once_R9: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid && (state_o == 3'd1 || state_o == 3'd0));

    assert_debug_holds_R11: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd5 && !dbg_release && !wdog_zero && !$past(reset_pin)
        |=> state_o == 3'd5);
endmodule

bind pstate_ctrl pstate_ctrl_chk #(
    .MOD_W(MOD_W), .IPR_W(IPR_W), .BCR_FIELDS(BCR_FIELDS), .WS_W(WS_W)
) u_chk (
    .clk(clk), .rst(rst), .reset_pin(reset_pin), .wdog_zero(wdog_zero),
    .irq_req(irq_req), .wake_req(wake_req), .dbg_req(dbg_req),
    .dbg_release(dbg_release), .state_o(state_o), .core_clk_en(core_clk_en),
    .intc_clk_en(intc_clk_en), .periph_clk_en(periph_clk_en),
    .periph_rst(periph_rst), .fetch_start(fetch_start), .vec_valid(vec_valid),
    .cfg_load(cfg_load), .mod_init(mod_init), .ipr_init(ipr_init),
    .bcr_init(bcr_init)
);

// File: tb/pstate_ctrl_tb.sv
module pstate_ctrl_tb;
    localparam int VEC_W = 6;
    localparam int ADDR_W = 16;
    localparam int BCR_W = 12;

    typedef struct packed {
        logic       irq;
        logic       wt;
        logic       sp;
        logic       wk;
        logic       dbg;
        logic       rel;
        logic [5:0] vec;
        logic [2:0] exp_state;
    } row_t;

    localparam int NROWS = 19;
    localparam row_t TBL [NROWS] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,6'd0, 3'd1},  // idle inputs stay in run
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,6'd0, 3'd3},  // R7 wait -> idle
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,6'd0, 3'd3},  // R7 stop/wake ignored in idle
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'd5, 3'd2},  // R7 irq wakes idle
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,6'd0, 3'd1},  // R9 back to run
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0, 3'd4},  // R8 stop -> sleep
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'd9, 3'd4},  // R8 irq ignored
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,6'd0, 3'd4},  // R8 debug ignored
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'd0, 3'd1},  // R8 wake
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,6'd3, 3'd5},  // R10 debug wins
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'd3, 3'd5},  // R11 irq ignored in debug
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,6'd0, 3'd1},  // R11 release
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,6'd7, 3'd2},  // R10 irq over stop/wait
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,6'd0, 3'd1},  // R9 back to run
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,6'd0, 3'd4},  // R10 stop over wait
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,6'd0, 3'd1},  // R8 wake
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,6'd0, 3'd3},  // R7 idle again
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,6'd0, 3'd5},  // R11 debug from idle
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,6'd0, 3'd1}   // R11 release
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reset_pin = 1'b0, wdog_zero = 1'b0, irq_req = 1'b0;
    logic [VEC_W-1:0] irq_vec = '0;
    logic wait_strobe = 1'b0, stop_strobe = 1'b0, wake_req = 1'b0;
    logic dbg_req = 1'b0, dbg_release = 1'b0;
    logic [2:0] state_o;
    logic core_clk_en, intc_clk_en, periph_clk_en, periph_rst, fetch_start;
    logic vec_valid, cfg_load;
    logic [ADDR_W-1:0] vec_addr;
    logic [15:0] mod_init, ipr_init;
    logic [BCR_W-1:0] bcr_init;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pstate_ctrl u_dut (
        .clk(clk), .rst(rst), .reset_pin(reset_pin), .wdog_zero(wdog_zero),
        .irq_req(irq_req), .irq_vec(irq_vec), .wait_strobe(wait_strobe),
        .stop_strobe(stop_strobe), .wake_req(wake_req), .dbg_req(dbg_req),
        .dbg_release(dbg_release), .state_o(state_o), .core_clk_en(core_clk_en),
        .intc_clk_en(intc_clk_en), .periph_clk_en(periph_clk_en),
        .periph_rst(periph_rst), .fetch_start(fetch_start), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .cfg_load(cfg_load), .mod_init(mod_init),
        .ipr_init(ipr_init), .bcr_init(bcr_init)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_en(input logic [2:0] s);
        case (s)
            3'd1, 3'd2:       return 3'b111;
            3'd0, 3'd3, 3'd5: return 3'b011;
            default:          return 3'b000;
        endcase
    endfunction

    task automatic clear_inputs();
        irq_req = 0; wait_strobe = 0; stop_strobe = 0; wake_req = 0;
        dbg_req = 0; dbg_release = 0; irq_vec = '0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk_reset_outputs(input string req);
        chk(req, {29'd0, state_o}, 32'd0);
        chk(req, {31'd0, periph_rst}, 32'd1);
        chk(req, {31'd0, cfg_load}, 32'd1);
        chk(req, {16'd0, mod_init}, 32'hFFFF);
        chk(req, {16'd0, ipr_init}, 32'd0);
        chk(req, {20'd0, bcr_init}, 32'hFFF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 block reset state, R4 values, R6 reset enables
        chk_reset_outputs("R1/R4 reset");
        chk("R6 reset enables", {29'd0, core_clk_en, intc_clk_en, periph_clk_en}, 32'b011);
        @(negedge clk) rst = 0;
        // R1 drain: still reset after 2 edges, run on the 3rd; R5 fetch pulse
        step(); chk("R1 drain1", {29'd0, state_o}, 32'd0);
        step(); chk("R1 drain2", {29'd0, state_o}, 32'd0);
        step(); chk("R5 run after drain", {29'd0, state_o}, 32'd1);
        chk("R5 fetch pulse", {31'd0, fetch_start}, 32'd1);
        step(); chk("R5 fetch one cycle", {31'd0, fetch_start}, 32'd0);

        // Table walk
        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            irq_req = TBL[i].irq; wait_strobe = TBL[i].wt; stop_strobe = TBL[i].sp;
            wake_req = TBL[i].wk; dbg_req = TBL[i].dbg; dbg_release = TBL[i].rel;
            irq_vec = TBL[i].vec;
            step();
            chk($sformatf("R7-R11 row %0d state", i), {29'd0, state_o}, {29'd0, TBL[i].exp_state});
            chk($sformatf("R6 row %0d enables", i),
                {29'd0, core_clk_en, intc_clk_en, periph_clk_en}, {29'd0, exp_en(TBL[i].exp_state)});
            chk($sformatf("R5 row %0d no fetch", i), {31'd0, fetch_start}, 32'd0);
            if (TBL[i].exp_state == 3'd2) begin
                chk("R9 vec valid", {31'd0, vec_valid}, 32'd1);
                chk("R9 vec addr", {16'd0, vec_addr}, {26'd0, TBL[i].vec} << 1);
            end
            @(negedge clk) clear_inputs();
        end

        // R9 largest vector, one-cycle valid
        @(negedge clk) begin irq_req = 1; irq_vec = 6'd63; end
        step();
        chk("R9 max vec addr", {16'd0, vec_addr}, 32'd126);
        @(negedge clk) clear_inputs();
        step();
        chk("R9 valid drops", {31'd0, vec_valid}, 32'd0);
        chk("R9 returns to run", {29'd0, state_o}, 32'd1);

        // R3 watchdog from idle, over a debug request
        @(negedge clk) wait_strobe = 1;
        step();
        @(negedge clk) begin clear_inputs(); wdog_zero = 1; dbg_req = 1; end
        step();
        chk_reset_outputs("R3 wdog reset");
        @(negedge clk) begin wdog_zero = 0; dbg_req = 0; end
        step();
        chk("R5 run after wdog", {29'd0, state_o}, 32'd1);
        chk("R5 fetch after wdog", {31'd0, fetch_start}, 32'd1);
        step();
        chk("R5 fetch clears", {31'd0, fetch_start}, 32'd0);

        // R2 pin reset from deep sleep
        @(negedge clk) stop_strobe = 1;
        step();
        @(negedge clk) begin stop_strobe = 0; reset_pin = 1; end
        step(); chk("R2 edge1 not yet", {29'd0, state_o}, 32'd4);
        step(); chk("R2 edge2 not yet", {29'd0, state_o}, 32'd4);
        step(); chk_reset_outputs("R2 pin reset");
        @(negedge clk) reset_pin = 0;
        step(); chk("R2 hold1", {29'd0, state_o}, 32'd0);
        step(); chk("R2 hold2", {29'd0, state_o}, 32'd0);
        step(); chk("R2 exit to run", {29'd0, state_o}, 32'd1);
        chk("R5 fetch after pin", {31'd0, fetch_start}, 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule